// File: doc/BRIEF.md
# Delayed completion discard timer

This block guards the delayed-completion slots on the inbound side of a bus bridge. A slot holds the result of a delayed request. That result exists once the request has finished on the internal bus. When this happens, a one-cycle completion-ready strobe arms a private counter for that slot. If the master that started the transaction comes back and claims the completion first, the slot logic raises a one-cycle retry-match strobe. That strobe stops the counter, and the completion is delivered by the surrounding bridge. If the counter runs out first, the block emits a one-cycle discard pulse for the slot, frees the slot and sets a sticky status flag for that side. The flag is the only indication: the block has no error output.

The bridge has two sides, A and B. Side A covers two slot groups: inbound read completions and inbound delayed-write completions. Side B covers inbound read completions only. Each side has its own timeout select and its own status flag.

- With the select low, the timeout is 2^10 bus clocks.
- With the select high, the timeout is 2^15 bus clocks.

Software clears a status flag by writing 1 to its clear input. Matching a retry to a slot by address or command is done outside this block and arrives here as the per-slot match strobe.

All inputs except the selects are single-cycle strobes sampled on the rising clock edge. Every output is a plain status level or pulse. No stream interface exists, so no valid/ready handshake and no back-pressure apply. An event is never stalled and never buffered.

Top module: `dct_discard_unit`

## Requirements
- R1: After reset every slot is free, every discard output is 0 and both status flags are 0. With no completion-ready strobe, no discard pulse ever occurs.
- R2: Arming happens only on a completion-ready strobe. With the side's select at 0 when the slot is armed, the slot's discard pulse appears in the cycle that follows the 1024th rising edge after the arming edge.
- R3: With the side's select at 1 when the slot is armed, the discard pulse appears in the cycle that follows the 32768th rising edge after the arming edge.
- R4: The select is captured when the slot is armed. Changing it while the counter runs does not change that slot's timeout.
- R5: A retry-match strobe on an armed slot frees the slot without a discard. This also holds when the strobe arrives on the same edge as the expiry.
- R6: A discard pulse lasts exactly one cycle and frees the slot, which can then be armed again with a fresh full timeout.
- R7: Every discard sets its side's status flag in the same cycle the discard pulse is high. The flag never rises without a discard.
- R8: A status flag stays set until its clear input is 1 on an edge. A clear on the same edge as a discard leaves the flag set.
- R9: The sides are independent. Each side uses only its own select, and each side's discards set only its own flag. Each slot has its own counter.
- R10: A completion-ready strobe on a slot that is already armed is ignored, and the running count is not restarted.
- R11: A retry-match strobe on a free slot has no effect.

Slot bit i of each strobe or discard vector belongs to slot i of that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| a_long_sel | input | 1 | Side A timeout select (0: 2^10, 1: 2^15) |
| b_long_sel | input | 1 | Side B timeout select (0: 2^10, 1: 2^15) |
| a_rd_cpl | input | A_RD_SLOTS | Side A read slot completion-ready strobes |
| a_rd_retry | input | A_RD_SLOTS | Side A read slot retry-match strobes |
| a_wr_cpl | input | A_WR_SLOTS | Side A delayed-write slot completion-ready strobes |
| a_wr_retry | input | A_WR_SLOTS | Side A delayed-write slot retry-match strobes |
| b_rd_cpl | input | B_RD_SLOTS | Side B read slot completion-ready strobes |
| b_rd_retry | input | B_RD_SLOTS | Side B read slot retry-match strobes |
| a_status_clr | input | 1 | Write-1-to-clear for side A status |
| b_status_clr | input | 1 | Write-1-to-clear for side B status |
| a_rd_discard | output | A_RD_SLOTS | Side A read slot discard pulses |
| a_wr_discard | output | A_WR_SLOTS | Side A delayed-write slot discard pulses |
| b_rd_discard | output | B_RD_SLOTS | Side B read slot discard pulses |
| a_status | output | 1 | Side A sticky discard status |
| b_status | output | 1 | Side B sticky discard status |

## Verification
The timer is tried with an untouched slot, and with slots left to expire under the short and under the long select. The long case runs with the select flipped in mid-count; this shows whether the setting is latched at arming or read live. Retries are placed in mid-count, exactly on the expiry edge, and on a free slot. These cases separate "retry wins" from "expiry wins" and show any lingering retry effect. A second arm in mid-count shows whether a busy slot restarts. A clear placed on the expiry edge, and both sides run together with opposite selects, show whether status priority and side isolation hold.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic {
    SLOT_FREE = 1'b0,
    SLOT_HELD = 1'b1
  } slot_state_e;

  // Last count value before expiry for a timeout of 2^log2 cycles
  function automatic logic [31:0] last_count(input int unsigned log2);
    return (32'd1 << log2) - 32'd1;
  endfunction

endpackage

// File: rtl/dct_slot.sv
module dct_slot
  import dct_pkg::*;
#(
  parameter int unsigned SHORT_LOG2 = 10,
  parameter int unsigned LONG_LOG2  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic long_sel,
  input  logic arm,
  input  logic retry,
  output logic expire,
  output logic discard
);

  localparam int unsigned CW = LONG_LOG2;
  localparam logic [CW-1:0] SHORT_LAST = CW'(last_count(SHORT_LOG2));
  localparam logic [CW-1:0] LONG_LAST  = CW'(last_count(LONG_LOG2));

  slot_state_e   state;
  logic          long_q;
  logic [CW-1:0] count;
  logic          at_last;

  assign at_last = (state == SLOT_HELD) &&
                   (count == (long_q ? LONG_LAST : SHORT_LAST));
  // retry on the final edge wins over expiry
  assign expire  = at_last && !retry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SLOT_FREE;
      long_q  <= 1'b0;
      count   <= '0;
      discard <= 1'b0;
    end else begin
      discard <= expire;
      if (state == SLOT_FREE) begin
        if (arm) begin
          state  <= SLOT_HELD;
          long_q <= long_sel;
          count  <= '0;
        end
      end else if (retry || at_last) begin
        state <= SLOT_FREE;
        count <= '0;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dct_side.sv
module dct_side #(
  parameter int unsigned NSLOT      = 4,
  parameter int unsigned SHORT_LOG2 = 10,
  parameter int unsigned LONG_LOG2  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             long_sel,
  input  logic [NSLOT-1:0] arm,
  input  logic [NSLOT-1:0] retry,
  input  logic             status_clr,
  output logic [NSLOT-1:0] discard,
  output logic             status
);

  logic [NSLOT-1:0] expire;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    dct_slot #(
      .SHORT_LOG2(SHORT_LOG2),
      .LONG_LOG2 (LONG_LOG2)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .long_sel(long_sel),
      .arm     (arm[s]),
      .retry   (retry[s]),
      .expire  (expire[s]),
      .discard (discard[s])
    );
  end

  // set beats clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= 1'b0;
    else        status <= (status && !status_clr) || (|expire);
  end

endmodule

// File: rtl/dct_discard_unit.sv
module dct_discard_unit #(
  parameter int unsigned A_RD_SLOTS = 2,
  parameter int unsigned A_WR_SLOTS = 2,
  parameter int unsigned B_RD_SLOTS = 2,
  parameter int unsigned SHORT_LOG2 = 10,
  parameter int unsigned LONG_LOG2  = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  a_long_sel,
  input  logic                  b_long_sel,
  input  logic [A_RD_SLOTS-1:0] a_rd_cpl,
  input  logic [A_RD_SLOTS-1:0] a_rd_retry,
  input  logic [A_WR_SLOTS-1:0] a_wr_cpl,
  input  logic [A_WR_SLOTS-1:0] a_wr_retry,
  input  logic [B_RD_SLOTS-1:0] b_rd_cpl,
  input  logic [B_RD_SLOTS-1:0] b_rd_retry,
  input  logic                  a_status_clr,
  input  logic                  b_status_clr,
  output logic [A_RD_SLOTS-1:0] a_rd_discard,
  output logic [A_WR_SLOTS-1:0] a_wr_discard,
  output logic [B_RD_SLOTS-1:0] b_rd_discard,
  output logic                  a_status,
  output logic                  b_status
);

  localparam int unsigned A_SLOTS = A_RD_SLOTS + A_WR_SLOTS;

  logic [A_SLOTS-1:0] a_disc;

  dct_side #(
    .NSLOT     (A_SLOTS),
    .SHORT_LOG2(SHORT_LOG2),
    .LONG_LOG2 (LONG_LOG2)
  ) u_side_a (
    .clk       (clk),
    .rst_n     (rst_n),
    .long_sel  (a_long_sel),
    .arm       ({a_wr_cpl, a_rd_cpl}),
    .retry     ({a_wr_retry, a_rd_retry}),
    .status_clr(a_status_clr),
    .discard   (a_disc),
    .status    (a_status)
  );

  assign a_rd_discard = a_disc[A_RD_SLOTS-1:0];
  assign a_wr_discard = a_disc[A_SLOTS-1:A_RD_SLOTS];

  dct_side #(
    .NSLOT     (B_RD_SLOTS),
    .SHORT_LOG2(SHORT_LOG2),
    .LONG_LOG2 (LONG_LOG2)
  ) u_side_b (
    .clk       (clk),
    .rst_n     (rst_n),
    .long_sel  (b_long_sel),
    .arm       (b_rd_cpl),
    .retry     (b_rd_retry),
    .status_clr(b_status_clr),
    .discard   (b_rd_discard),
    .status    (b_status)
  );

endmodule

// File: rtl/dct_discard_checker.sv
module dct_discard_checker #(
  parameter int unsigned A_RD_SLOTS = 2,
  parameter int unsigned A_WR_SLOTS = 2,
  parameter int unsigned B_RD_SLOTS = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [A_RD_SLOTS-1:0] a_rd_retry,
  input logic [A_WR_SLOTS-1:0] a_wr_retry,
  input logic [B_RD_SLOTS-1:0] b_rd_retry,
  input logic                  a_status_clr,
  input logic                  b_status_clr,
  input logic [A_RD_SLOTS-1:0] a_rd_discard,
  input logic [A_WR_SLOTS-1:0] a_wr_discard,
  input logic [B_RD_SLOTS-1:0] b_rd_discard,
  input logic                  a_status,
  input logic                  b_status
);

  logic [A_RD_SLOTS+A_WR_SLOTS-1:0] a_disc, a_retry;
  assign a_disc  = {a_wr_discard, a_rd_discard};
  assign a_retry = {a_wr_retry, a_rd_retry};

  p_disc_flags_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_disc != '0) |-> a_status);
  p_disc_flags_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rd_discard != '0) |-> b_status);
  p_rise_needs_disc_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_status) |-> (a_disc != '0));
  p_rise_needs_disc_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_status) |-> (b_rd_discard != '0));
  p_sticky_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_status && !a_status_clr) |=> a_status);
  p_sticky_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (b_status && !b_status_clr) |=> b_status);
  p_clear_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_status && a_status_clr) |=> (a_status == (a_disc != '0)));
  p_retry_wins_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_retry != '0) |=> ((a_disc & $past(a_retry)) == '0));
  p_retry_wins_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rd_retry != '0) |=> ((b_rd_discard & $past(b_rd_retry)) == '0));
  p_one_cycle_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_disc != '0) |=> ((a_disc & $past(a_disc)) == '0));
  p_one_cycle_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rd_discard != '0) |=> ((b_rd_discard & $past(b_rd_discard)) == '0));

endmodule

bind dct_discard_unit dct_discard_checker #(
  .A_RD_SLOTS(A_RD_SLOTS),
  .A_WR_SLOTS(A_WR_SLOTS),
  .B_RD_SLOTS(B_RD_SLOTS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .a_rd_retry  (a_rd_retry),
  .a_wr_retry  (a_wr_retry),
  .b_rd_retry  (b_rd_retry),
  .a_status_clr(a_status_clr),
  .b_status_clr(b_status_clr),
  .a_rd_discard(a_rd_discard),
  .a_wr_discard(a_wr_discard),
  .b_rd_discard(b_rd_discard),
  .a_status    (a_status),
  .b_status    (b_status)
);

// File: tb/tb_dct_discard_unit.sv
`timescale 1ns/1ps
module tb_dct_discard_unit;

  localparam int LIM_S = 1024;
  localparam int LIM_L = 32768;
  localparam int NT    = 6; // {b_rd[1:0], a_wr[1:0], a_rd[1:0]}

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_long_sel = 1'b0, b_long_sel = 1'b0;
  logic [1:0] a_rd_cpl = '0, a_rd_retry = '0, a_wr_cpl = '0, a_wr_retry = '0;
  logic [1:0] b_rd_cpl = '0, b_rd_retry = '0;
  logic a_status_clr = 1'b0, b_status_clr = 1'b0;
  logic [1:0] a_rd_discard, a_wr_discard, b_rd_discard;
  logic a_status, b_status;

  always #2.5 clk = ~clk;

  dct_discard_unit dut (
    .clk(clk), .rst_n(rst_n), .a_long_sel(a_long_sel), .b_long_sel(b_long_sel),
    .a_rd_cpl(a_rd_cpl), .a_rd_retry(a_rd_retry), .a_wr_cpl(a_wr_cpl),
    .a_wr_retry(a_wr_retry), .b_rd_cpl(b_rd_cpl), .b_rd_retry(b_rd_retry),
    .a_status_clr(a_status_clr), .b_status_clr(b_status_clr),
    .a_rd_discard(a_rd_discard), .a_wr_discard(a_wr_discard),
    .b_rd_discard(b_rd_discard), .a_status(a_status), .b_status(b_status)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int k;
  int first_k [NT];
  int n_pulse [NT];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // k counts edges since the arming edge (arming edge is k=0)
  task automatic begin_watch();
    k = -1;
    for (int i = 0; i < NT; i++) begin
      first_k[i] = -1;
      n_pulse[i] = 0;
    end
  endtask

  task automatic step(input int n);
    logic [NT-1:0] all;
    repeat (n) begin
      @(negedge clk);
      k++;
      all = {b_rd_discard, a_wr_discard, a_rd_discard};
      for (int i = 0; i < NT; i++)
        if (all[i]) begin
          n_pulse[i]++;
          if (first_k[i] < 0) first_k[i] = k;
        end
      a_rd_cpl = '0; a_rd_retry = '0; a_wr_cpl = '0; a_wr_retry = '0;
      b_rd_cpl = '0; b_rd_retry = '0; a_status_clr = 1'b0; b_status_clr = 1'b0;
    end
  endtask

  task automatic step_to(input int target);
    while (k < target) step(1);
  endtask

  task automatic clear_both();
    a_status_clr = 1'b1; b_status_clr = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    check(a_rd_discard == 0 && a_wr_discard == 0 && b_rd_discard == 0, "R1",
          "discards after reset", {a_rd_discard, a_wr_discard, b_rd_discard}, 0);
    check(a_status == 0 && b_status == 0, "R1", "status after reset",
          {a_status, b_status}, 0);
    begin_watch();
    step_to(2000);
    check(n_pulse[0] + n_pulse[1] + n_pulse[2] + n_pulse[3] + n_pulse[4] + n_pulse[5] == 0,
          "R1", "pulses without arming", n_pulse[0] + n_pulse[2] + n_pulse[4], 0);
  endtask

  task automatic t_short_expiry();
    begin_watch();
    a_long_sel = 1'b0;
    a_wr_cpl[1] = 1'b1;
    step_to(LIM_S + 3);
    check(first_k[3] == LIM_S, "R2", "short discard edge", first_k[3], LIM_S);
    check(n_pulse[3] == 1, "R6", "short pulse count", n_pulse[3], 1);
    check(n_pulse[0] + n_pulse[1] + n_pulse[2] + n_pulse[4] + n_pulse[5] == 0, "R9",
          "other slots quiet", n_pulse[0] + n_pulse[1] + n_pulse[2], 0);
    check(a_status == 1, "R7", "side A status set", a_status, 1);
    check(b_status == 0, "R9", "side B status untouched", b_status, 0);
  endtask

  task automatic t_status_clear();
    step(50);
    check(a_status == 1, "R8", "status sticky", a_status, 1);
    a_status_clr = 1'b1;
    step(1);
    check(a_status == 0, "R8", "status cleared", a_status, 0);
    begin_watch();
    a_rd_cpl[0] = 1'b1;
    step_to(LIM_S - 1);
    a_status_clr = 1'b1;
    step(1);
    check(a_rd_discard[0] == 1, "R2", "discard on expiry edge", a_rd_discard[0], 1);
    check(a_status == 1, "R8", "set beats clear", a_status, 1);
    a_status_clr = 1'b1;
    step(1);
    check(a_status == 0, "R8", "cleared afterwards", a_status, 0);
  endtask

  task automatic t_retry();
    begin_watch();
    a_rd_cpl[1] = 1'b1;
    step_to(499);
    a_rd_retry[1] = 1'b1;
    step_to(LIM_S + 5);
    check(n_pulse[1] == 0, "R5", "mid-count retry", n_pulse[1], 0);
    begin_watch();
    a_rd_cpl[1] = 1'b1;
    step_to(LIM_S - 1);
    a_rd_retry[1] = 1'b1;
    step_to(LIM_S + 5);
    check(n_pulse[1] == 0, "R5", "retry on expiry edge", n_pulse[1], 0);
    check(a_status == 0, "R5", "no status after retries", a_status, 0);
  endtask

  task automatic t_busy_rearm();
    begin_watch();
    a_rd_cpl[0] = 1'b1;
    step_to(599);
    a_rd_cpl[0] = 1'b1;
    step_to(LIM_S + 700);
    check(first_k[0] == LIM_S, "R10", "rearm ignored", first_k[0], LIM_S);
    check(n_pulse[0] == 1, "R10", "single discard", n_pulse[0], 1);
  endtask

  task automatic t_after_discard();
    clear_both();
    begin_watch();
    a_rd_retry[0] = 1'b1;   // slot 0 free here
    step(1);
    check(a_rd_discard[0] == 0 && a_status == 0, "R11", "retry on free slot",
          a_rd_discard[0], 0);
    a_rd_cpl[0] = 1'b1;     // arming edge is k=1
    step_to(LIM_S + 4);
    check(first_k[0] == LIM_S + 1, "R6", "fresh timeout after discard",
          first_k[0], LIM_S + 1);
    check(n_pulse[0] == 1, "R11", "one discard after rearm", n_pulse[0], 1);
  endtask

  task automatic t_long_and_latch();
    clear_both();
    begin_watch();
    a_long_sel = 1'b1; b_long_sel = 1'b0;
    a_rd_cpl[0] = 1'b1; b_rd_cpl[0] = 1'b1;
    step(1);
    a_long_sel = 1'b0; b_long_sel = 1'b1;   // flip after arming
    step_to(LIM_S + 2);
    check(first_k[4] == LIM_S, "R4", "side B keeps short timeout", first_k[4], LIM_S);
    check(n_pulse[0] == 0, "R4", "side A not short", n_pulse[0], 0);
    check(b_status == 1 && a_status == 0, "R9", "status isolation",
          {a_status, b_status}, 1);
    step_to(LIM_L + 2);
    check(first_k[0] == LIM_L, "R3", "long discard edge", first_k[0], LIM_L);
    check(n_pulse[0] == 1, "R3", "long pulse count", n_pulse[0], 1);
    check(a_status == 1, "R7", "side A status after long", a_status, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_expiry();
    t_status_clear();
    t_retry();
    t_busy_rearm();
    t_after_discard();
    t_long_and_latch();
    done = 1'b1;
    report();
  end

endmodule